// File: doc/BRIEF.md
# Four-Bit Add, Subtract and AND Unit

This block is a purely combinational arithmetic logic unit for four-bit operands. Two control inputs pick one of three operations: addition, subtraction, or a bitwise AND. The outputs are a four-bit result and a single signed-overflow flag, five bits in total. Nothing inside the block is clocked, so the outputs follow the inputs after the gate delay alone.

A single ripple-carry adder serves both arithmetic operations. For subtraction, a bank of XOR gates inverts the second operand. The subtract control also drives the adder carry-in, so the adder sees the two's complement of the second operand. The AND is computed on its own path. A bank of 2:1 multiplexers on one shared select line then chooses between the adder output and the AND output.

The unit is meant to sit inside a small datapath that supplies the operands and the two control bits and uses the result in the same cycle.

Top module: `alu4_mux`

## Requirements
- R1: With `sel_logic` = 0 and `sub_mode` = 0, `result` equals (`op_a` + `op_b`) modulo 16.
- R2: With `sel_logic` = 0 and `sub_mode` = 1, `result` equals (`op_a` − `op_b`) modulo 16, formed by inverting every bit of `op_b` and adding it to `op_a` with a carry-in of one.
- R3: With `sel_logic` = 1, `result` equals `op_a` AND `op_b` bit by bit, whatever the value of `sub_mode`.
- R4: During addition, `ovf` is 1 exactly when `op_a` and `op_b` have the same bit 3 (sign) and the sign of `result` differs from it.
- R5: During subtraction, `ovf` is 1 exactly when the signs (bit 3) of `op_a` and `op_b` differ and the sign of `result` differs from the sign of `op_a`.
- R6: With `sel_logic` = 1, `ovf` is 0.
- R7: The block has no storage. Both outputs reflect the present inputs alone, with no clock edge needed after an input change.
- R8: Subtracting `op_b` = 0 returns `op_a` unchanged with `ovf` = 0, even though the inverted operand plus carry-in produces a carry out of bit 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 | First operand |
| op_b | input | 4 | Second operand; inverted on the way to the adder when subtracting |
| sel_logic | input | 1 | Shared multiplexer select: 0 = adder output, 1 = bitwise AND |
| sub_mode | input | 1 | 0 = add, 1 = subtract; also the adder carry-in |
| result | output | 4 | Selected four-bit result |
| ovf | output | 1 | Signed overflow of the arithmetic path; 0 when AND is selected |

## Verification
The bench sweeps all 1024 combinations of operands and controls and compares each one against sums, differences and sign rules computed with integer arithmetic.

Four corner areas get particular attention:
- Operands near the signed limits (7, 8, 15) find an overflow flag built from the wrong carries or from unsigned carry-out. Such a design would flag 15 + 1, or would miss 7 + 1.
- Subtracting zero finds a design that reports the carry out of the inverted path as overflow.
- A missing carry-in would be off by one on every difference.
- With AND selected, a design that lets the subtract control leak through would show inverted bits or a stray overflow flag.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
    localparam int ALU_W = 4;
endpackage

// File: rtl/alu4_cond_inv.sv
module alu4_cond_inv #(
    parameter int W = 4
) (
    input  logic [W-1:0] din,
    input  logic         inv,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_xor
        assign dout[i] = din[i] ^ inv;
    end
endmodule

// File: rtl/alu4_ripple.sv
module alu4_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_into_msb,
    output logic         c_out
);
    logic [W:0] carry;

    assign carry[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i]     = x[i] ^ y[i] ^ carry[i];
        assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
    end

    assign c_into_msb = carry[W-1];
    assign c_out      = carry[W];

    // the bit-level chain must agree with a whole-word addition (R1, R2)
    always_comb begin
        p_ripple_sum_r1: assert ({c_out, sum} ==
            ({1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin}))
            else $error("ripple chain disagrees with word sum");
    end
endmodule

// File: rtl/alu4_mux_bank.sv
module alu4_mux_bank #(
    parameter int W = 4
) (
    input  logic [W-1:0] d0,
    input  logic [W-1:0] d1,
    input  logic         sel,
    output logic [W-1:0] y
);
    for (genvar i = 0; i < W; i++) begin : g_mux
        assign y[i] = sel ? d1[i] : d0[i];
    end
endmodule

// File: rtl/alu4_mux.sv
module alu4_mux
    import alu4_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         sel_logic,
    input  logic         sub_mode,
    output logic [W-1:0] result,
    output logic         ovf
);
    localparam int MSB = W - 1;

    typedef struct packed {
        logic [W-1:0] res;
        logic         ovf;
    } alu_out_t;

    alu_out_t     out_d;
    logic [W-1:0] b_eff;
    logic [W-1:0] sum_w;
    logic [W-1:0] and_w;
    logic [W-1:0] mux_w;
    logic         c_msb;
    logic         c_top;

    alu4_cond_inv #(.W(W)) u_inv (
        .din (op_b),
        .inv (sub_mode),
        .dout(b_eff)
    );

    alu4_ripple #(.W(W)) u_add (
        .x         (op_a),
        .y         (b_eff),
        .cin       (sub_mode),
        .sum       (sum_w),
        .c_into_msb(c_msb),
        .c_out     (c_top)
    );

    assign and_w = op_a & op_b;

    alu4_mux_bank #(.W(W)) u_sel (
        .d0 (sum_w),
        .d1 (and_w),
        .sel(sel_logic),
        .y  (mux_w)
    );

    always_comb begin
        out_d.res = mux_w;
        out_d.ovf = (c_top ^ c_msb) & ~sel_logic;
    end

    assign result = out_d.res;
    assign ovf    = out_d.ovf;

    always_comb begin
        if (sel_logic) begin
            p_and_path_r3: assert (result == (op_a & op_b))
                else $error("logic path result wrong");
            p_no_overflow_r6: assert (!ovf)
                else $error("overflow raised on logic path");
        end else if (!sub_mode) begin
            p_add_r1: assert (result == W'(op_a + op_b))
                else $error("sum wrong");
            p_ovf_add_r4: assert (ovf == ((op_a[MSB] == op_b[MSB]) &&
                                          (result[MSB] != op_a[MSB])))
                else $error("add overflow wrong");
        end else begin
            p_sub_r2: assert (result == W'(op_a - op_b))
                else $error("difference wrong");
            p_ovf_sub_r5: assert (ovf == ((op_a[MSB] != op_b[MSB]) &&
                                          (result[MSB] != op_a[MSB])))
                else $error("sub overflow wrong");
        end
    end
endmodule

// File: tb/test_alu4_mux.sv
module test_alu4_mux;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_a = 4'd0;
    logic [3:0] op_b = 4'd0;
    logic       sel_logic = 1'b0;
    logic       sub_mode = 1'b0;
    logic [3:0] result;
    logic       ovf;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu4_mux i_alu4_mux (
        .op_a     (op_a),
        .op_b     (op_b),
        .sel_logic(sel_logic),
        .sub_mode (sub_mode),
        .result   (result),
        .ovf      (ovf)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish, actual cycles=%0d expected<=%0d",
                     cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s a=%0d b=%0d sel=%0b sub=%0b: actual=%0d expected=%0d",
                     req, op_a, op_b, sel_logic, sub_mode, act, exp);
        end
    endtask

    initial begin
        // reset state: zero inputs give zero outputs (R1, R7)
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset result", int'(result), 0);
        check("R7 reset ovf", int'(ovf), 0);
        rst_n = 1'b1;

        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < 2; m++) begin
                for (int a = 0; a < 16; a++) begin
                    for (int b = 0; b < 16; b++) begin
                        int  exp_r;
                        int  exp_o;
                        bit  sa, sb, sr;
                        string rr, ro;
                        @(posedge clk);
                        op_a      = 4'(a);
                        op_b      = 4'(b);
                        sel_logic = s[0];
                        sub_mode  = m[0];
                        sa = (a >= 8);
                        sb = (b >= 8);
                        if (s == 1) begin
                            exp_r = a & b;
                            exp_o = 0;
                            rr = "R3";
                            ro = "R6";
                        end else if (m == 0) begin
                            exp_r = (a + b) % 16;
                            sr = (exp_r >= 8);
                            exp_o = (sa == sb && sr != sa) ? 1 : 0;
                            rr = "R1";
                            ro = "R4";
                        end else begin
                            exp_r = (a - b + 16) % 16;
                            sr = (exp_r >= 8);
                            exp_o = (sa != sb && sr != sa) ? 1 : 0;
                            rr = (b == 0) ? "R8" : "R2";
                            ro = (b == 0) ? "R8" : "R5";
                        end
                        // combinational: settle within the same cycle (R7)
                        #1;
                        check(rr, int'(result), exp_r);
                        check(ro, int'(ovf), exp_o);
                    end
                end
            end
        end

        // input change without any clock edge in between (R7)
        @(negedge clk);
        op_a = 4'd7; op_b = 4'd1; sel_logic = 1'b0; sub_mode = 1'b0;
        #1;
        check("R7 no-clock result", int'(result), 8);
        check("R7 no-clock ovf", int'(ovf), 1);
        op_a = 4'd6; op_b = 4'd12; sel_logic = 1'b1; sub_mode = 1'b1;
        #1;
        check("R7 no-clock and", int'(result), 4);
        check("R7 no-clock ovf off", int'(ovf), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule